// File: doc/BRIEF.md
# Range Register Update Sequencer

This block loads a shadow copy of memory-type range settings into an external register file. It reaches that file through a 64-bit register port with a request/acknowledge handshake. Cache, TLB and control-register actions go out as request/acknowledge commands to the logic that owns them.

On a start pulse the block first makes the machine safe and saves the default-type register. It then walks every range register and reads each one. It writes a register only when the value differs from the shadow in the bits that matter. Last, it restores the saved default type, with any new fields patched in, and undoes the safe state.

When the run ends the block gives a one-cycle done pulse. With it comes a three-bit mask that shows which groups of registers were rewritten: variable pairs, fixed registers, or the default type.

Top module: `range_reg_sequencer`

## Requirements
- R1: After start, commands are issued in this order: cache-disable set (op 0), cache flush (op 1), page-global clear (op 2, only when `has_pge` was high at start), TLB flush (op 3). Each command waits for its acknowledge. `cmd_req` and `cmd_op` hold until `cmd_ack`.
- R2: After the entry commands, the default-type register at `DEF_ADDR` is read. It is then written with its bits 7:0 and 11:10 cleared. Both happen before any range register is touched.
- R3: A register request holds `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` stable until `reg_ack`. No request or command is raised out of reset.
- R4: The walk visits the variable pairs in ascending index i: base at `VAR_ADDR0+2i`, then mask at `VAR_ADDR0+2i+1`. It then visits the fixed registers at `FIX_ADDR0+k` for k = 0 to 10. Slot 0 holds 64 KiB granules, slots 1 and 2 hold 16 KiB granules, and slots 3 to 10 hold 4 KiB granules. Each register is read, and is written with its shadow value only on a mismatch.
- R5: Variable-register comparison ignores these bits: bits 11:8 of a base, bits 10:0 of a mask, and all high bits at or above `PA_BITS`. Any write to a variable register sets change-mask bit 0.
- R6: Fixed registers are compared on all 64 bits, and a write sets change-mask bit 1. When `has_fixed` was low at start, the fixed registers are not accessed.
- R7: In the saved default value, bits 7:0 are replaced by `want_type` and bits 11:10 by `want_en` when either field differs. A difference sets change-mask bit 2.
- R8: The exit order is: TLB flush (op 3), a write of the saved default value to `DEF_ADDR`, cache-disable clear (op 4), and page-global restore (op 5, only when page-global handling was active).
- R9: `chg_mask` is cleared at start and is valid while `done` is high.
- R10: `done` is high for exactly one cycle per run, and `busy` is low in the cycle after it.
- R11: A start pulse while `busy` is high is ignored. It causes no second run and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an update run (ignored when busy) |
| has_fixed | input | 1 | Fixed-range registers exist; sampled at start |
| has_pge | input | 1 | Page-global enable exists; sampled at start |
| want_type | input | 8 | Wanted default memory type |
| want_en | input | 2 | Wanted enable pair for the default-type register |
| shadow_var_base | input | NVAR*64 | Shadow base values, pair i in bits i*64 upward |
| shadow_var_mask | input | NVAR*64 | Shadow mask values, pair i in bits i*64 upward |
| shadow_fix | input | 11*64 | Shadow fixed values, slot k in bits k*64 upward |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | AW | Register address |
| reg_wdata | output | 64 | Write data |
| reg_ack | input | 1 | Access complete |
| reg_rdata | input | 64 | Read data, valid with `reg_ack` |
| cmd_req | output | 1 | Command request |
| cmd_op | output | 3 | Command code (0 to 5, see R1 and R8) |
| cmd_ack | input | 1 | Command complete |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| chg_mask | output | 3 | bit0 variable, bit1 fixed, bit2 default type |

## Verification
The test uses four patterns. In the first, every shadow equals the file, so the only writes are the two default-type writes. In the second, shadows differ only in ignored bits: base 11:8, mask 10:0 and address bits above the implemented width. This pattern separates correct compare masks from full-width compares. In the third, every register differs, which shows the full write order and all three change bits. The fourth is a random per-register mix, run with and without the fixed capability and page-global feature. These runs separate the skip paths and the optional commands from the fixed order of bracket steps.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   localparam int FIX_REGS = 11;

   localparam logic [31:0] BASE_LO_CARE = 32'hFFFF_F0FF;
   localparam logic [31:0] MASK_LO_CARE = 32'hFFFF_F800;
   localparam logic [63:0] DEF_FIELDS   = 64'h0000_0000_0000_0CFF;

   typedef enum logic [2:0] {
      OP_CD_SET      = 3'd0,
      OP_CACHE_FLUSH = 3'd1,
      OP_PG_CLR      = 3'd2,
      OP_TLB_FLUSH   = 3'd3,
      OP_CD_CLR      = 3'd4,
      OP_PG_SET      = 3'd5
   } rrs_op_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CD_SET,
      S_CFLUSH,
      S_PG_CLR,
      S_TLB_IN,
      S_SAVE_RD,
      S_DIS_WR,
      S_ITEM_RD,
      S_ITEM_WR,
      S_DEF_UPD,
      S_TLB_OUT,
      S_RESTORE_WR,
      S_CD_CLR,
      S_PG_SET,
      S_DONE
   } rrs_state_e;

endpackage

// File: rtl/rrs_masked_cmp.sv
module rrs_masked_cmp #(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] care,
   output logic         differ
);
   assign differ = |((a ^ b) & care);
endmodule

// File: rtl/rrs_item_sel.sv
module rrs_item_sel
   import rrs_pkg::*;
#(
   parameter int          NVAR      = 8,
   parameter int          AW        = 12,
   parameter int          PA_BITS   = 36,
   parameter int unsigned VAR_ADDR0 = 'h100,
   parameter int unsigned FIX_ADDR0 = 'h140,
   parameter int          IW        = 5
) (
   input  logic [IW-1:0]          idx,
   input  logic [NVAR*64-1:0]     shadow_var_base,
   input  logic [NVAR*64-1:0]     shadow_var_mask,
   input  logic [FIX_REGS*64-1:0] shadow_fix,
   output logic [AW-1:0]          addr,
   output logic [63:0]            value,
   output logic [63:0]            care,
   output logic                   is_fixed
);
   localparam int NVREG  = 2 * NVAR;
   localparam int NITEMS = NVREG + FIX_REGS;
   localparam int NSLOT  = 1 << IW;
   localparam logic [31:0] HI_CARE = 32'((64'd1 << (PA_BITS - 32)) - 64'd1);

   logic [AW-1:0] addr_a  [NSLOT];
   logic [63:0]   val_a   [NSLOT];
   logic [63:0]   care_a  [NSLOT];
   logic          fixed_a [NSLOT];

   for (genvar i = 0; i < NVAR; i++) begin : g_var
      assign addr_a[2*i]    = AW'(VAR_ADDR0 + 2*i);
      assign val_a[2*i]     = shadow_var_base[i*64 +: 64];
      assign care_a[2*i]    = {HI_CARE, BASE_LO_CARE};
      assign fixed_a[2*i]   = 1'b0;
      assign addr_a[2*i+1]  = AW'(VAR_ADDR0 + 2*i + 1);
      assign val_a[2*i+1]   = shadow_var_mask[i*64 +: 64];
      assign care_a[2*i+1]  = {HI_CARE, MASK_LO_CARE};
      assign fixed_a[2*i+1] = 1'b0;
   end

   for (genvar k = 0; k < FIX_REGS; k++) begin : g_fix
      assign addr_a[NVREG+k]  = AW'(FIX_ADDR0 + k);
      assign val_a[NVREG+k]   = shadow_fix[k*64 +: 64];
      assign care_a[NVREG+k]  = '1;
      assign fixed_a[NVREG+k] = 1'b1;
   end

   for (genvar p = NITEMS; p < NSLOT; p++) begin : g_pad
      assign addr_a[p]  = '0;
      assign val_a[p]   = '0;
      assign care_a[p]  = '0;
      assign fixed_a[p] = 1'b0;
   end

   assign addr     = addr_a[idx];
   assign value    = val_a[idx];
   assign care     = care_a[idx];
   assign is_fixed = fixed_a[idx];
endmodule

// File: rtl/range_reg_sequencer.sv
module range_reg_sequencer
   import rrs_pkg::*;
#(
   parameter int          NVAR      = 8,
   parameter int          AW        = 12,
   parameter int          PA_BITS   = 36,
   parameter int unsigned VAR_ADDR0 = 'h100,
   parameter int unsigned FIX_ADDR0 = 'h140,
   parameter int unsigned DEF_ADDR  = 'h1F0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   has_fixed,
   input  logic                   has_pge,
   input  logic [7:0]             want_type,
   input  logic [1:0]             want_en,
   input  logic [NVAR*64-1:0]     shadow_var_base,
   input  logic [NVAR*64-1:0]     shadow_var_mask,
   input  logic [FIX_REGS*64-1:0] shadow_fix,
   output logic                   reg_req,
   output logic                   reg_we,
   output logic [AW-1:0]          reg_addr,
   output logic [63:0]            reg_wdata,
   input  logic                   reg_ack,
   input  logic [63:0]            reg_rdata,
   output logic                   cmd_req,
   output logic [2:0]             cmd_op,
   input  logic                   cmd_ack,
   output logic                   busy,
   output logic                   done,
   output logic [2:0]             chg_mask
);
   localparam int NVREG  = 2 * NVAR;
   localparam int NITEMS = NVREG + FIX_REGS;
   localparam int IW     = $clog2(NITEMS);

   if (NVAR < 1 || NVAR > 64) begin : g_bad_nvar
      $error("NVAR must be in 1..64");
   end
   if (PA_BITS < 33 || PA_BITS > 63) begin : g_bad_pa
      $error("PA_BITS must be in 33..63");
   end
   if (AW < 4 || AW > 32) begin : g_bad_aw
      $error("AW must be in 4..32");
   end

   rrs_state_e    state;
   logic [IW-1:0] idx;
   logic [63:0]   saved;
   logic          fix_en, pg_en;
   logic [AW-1:0] item_addr;
   logic [63:0]   item_val, item_care;
   logic          item_fixed, item_differ, def_differ;
   logic [63:0]   def_want;
   logic          last_item;
   rrs_op_e       op_now;

   rrs_item_sel #(
      .NVAR(NVAR), .AW(AW), .PA_BITS(PA_BITS),
      .VAR_ADDR0(VAR_ADDR0), .FIX_ADDR0(FIX_ADDR0), .IW(IW)
   ) i_item_sel (
      .idx(idx),
      .shadow_var_base(shadow_var_base),
      .shadow_var_mask(shadow_var_mask),
      .shadow_fix(shadow_fix),
      .addr(item_addr),
      .value(item_val),
      .care(item_care),
      .is_fixed(item_fixed)
   );

   rrs_masked_cmp #(.W(64)) i_item_cmp (
      .a(reg_rdata), .b(item_val), .care(item_care), .differ(item_differ)
   );

   assign def_want = {52'd0, want_en, 2'b00, want_type};

   rrs_masked_cmp #(.W(64)) i_def_cmp (
      .a(saved), .b(def_want), .care(DEF_FIELDS), .differ(def_differ)
   );

   assign last_item = (idx == IW'(NITEMS - 1)) ||
                      ((idx == IW'(NVREG - 1)) && !fix_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         idx      <= '0;
         saved    <= '0;
         fix_en   <= 1'b0;
         pg_en    <= 1'b0;
         chg_mask <= '0;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               state    <= S_CD_SET;
               idx      <= '0;
               chg_mask <= '0;
               fix_en   <= has_fixed;
               pg_en    <= has_pge;
            end
            S_CD_SET:  if (cmd_ack) state <= S_CFLUSH;
            S_CFLUSH:  if (cmd_ack) state <= pg_en ? S_PG_CLR : S_TLB_IN;
            S_PG_CLR:  if (cmd_ack) state <= S_TLB_IN;
            S_TLB_IN:  if (cmd_ack) state <= S_SAVE_RD;
            S_SAVE_RD: if (reg_ack) begin
               saved <= reg_rdata;
               state <= S_DIS_WR;
            end
            S_DIS_WR:  if (reg_ack) state <= S_ITEM_RD;
            S_ITEM_RD: if (reg_ack) begin
               if (item_differ)    state <= S_ITEM_WR;
               else if (last_item) state <= S_DEF_UPD;
               else begin
                  idx   <= idx + 1'b1;
                  state <= S_ITEM_RD;
               end
            end
            S_ITEM_WR: if (reg_ack) begin
               if (item_fixed) chg_mask[1] <= 1'b1;
               else            chg_mask[0] <= 1'b1;
               if (last_item) state <= S_DEF_UPD;
               else begin
                  idx   <= idx + 1'b1;
                  state <= S_ITEM_RD;
               end
            end
            S_DEF_UPD: begin
               if (def_differ) begin
                  saved       <= (saved & ~DEF_FIELDS) | def_want;
                  chg_mask[2] <= 1'b1;
               end
               state <= S_TLB_OUT;
            end
            S_TLB_OUT:    if (cmd_ack) state <= S_RESTORE_WR;
            S_RESTORE_WR: if (reg_ack) state <= S_CD_CLR;
            S_CD_CLR:     if (cmd_ack) state <= pg_en ? S_PG_SET : S_DONE;
            S_PG_SET:     if (cmd_ack) state <= S_DONE;
            S_DONE:       state <= S_IDLE;
            default:      state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_req = 1'b1;
      op_now  = OP_CD_SET;
      case (state)
         S_CD_SET:  op_now = OP_CD_SET;
         S_CFLUSH:  op_now = OP_CACHE_FLUSH;
         S_PG_CLR:  op_now = OP_PG_CLR;
         S_TLB_IN,
         S_TLB_OUT: op_now = OP_TLB_FLUSH;
         S_CD_CLR:  op_now = OP_CD_CLR;
         S_PG_SET:  op_now = OP_PG_SET;
         default:   cmd_req = 1'b0;
      endcase
   end
   assign cmd_op = op_now;

   always_comb begin
      reg_req   = 1'b0;
      reg_we    = 1'b0;
      reg_addr  = AW'(DEF_ADDR);
      reg_wdata = '0;
      case (state)
         S_SAVE_RD: reg_req = 1'b1;
         S_DIS_WR: begin
            reg_req   = 1'b1;
            reg_we    = 1'b1;
            reg_wdata = saved & ~DEF_FIELDS;
         end
         S_ITEM_RD: begin
            reg_req  = 1'b1;
            reg_addr = item_addr;
         end
         S_ITEM_WR: begin
            reg_req   = 1'b1;
            reg_we    = 1'b1;
            reg_addr  = item_addr;
            reg_wdata = item_val;
         end
         S_RESTORE_WR: begin
            reg_req   = 1'b1;
            reg_we    = 1'b1;
            reg_wdata = saved;
         end
         default: ;
      endcase
   end

   assign busy = (state != S_IDLE);
   assign done = (state == S_DONE);

   p_cmd_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (cmd_req && cmd_op == 3'd0 && !reg_req));

   p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op)));

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_ack) |=>
         (reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata)));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   p_mask_settled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done) |-> $stable(chg_mask));

   p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!reg_req && !cmd_req));
endmodule

// File: tb/test_range_reg_sequencer.sv
module test_range_reg_sequencer;
   localparam int NV   = 8;
   localparam int AW   = 12;
   localparam int PA   = 36;
   localparam int VA0  = 'h100;
   localparam int FA0  = 'h140;
   localparam int DA   = 'h1F0;
   localparam int NFX  = 11;
   localparam int NIT  = 2 * NV + NFX;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic                start = 1'b0, has_fixed = 1'b1, has_pge = 1'b1;
   logic [7:0]          want_type = '0;
   logic [1:0]          want_en = '0;
   logic [NV*64-1:0]    sh_base = '0, sh_mask = '0;
   logic [NFX*64-1:0]   sh_fix = '0;
   logic                reg_req, reg_we, cmd_req, busy, done;
   logic [AW-1:0]       reg_addr;
   logic [63:0]         reg_wdata;
   logic                reg_ack = 1'b0, cmd_ack = 1'b0;
   logic [63:0]         reg_rdata = '0;
   logic [2:0]          cmd_op, chg_mask;

   range_reg_sequencer #(
      .NVAR(NV), .AW(AW), .PA_BITS(PA),
      .VAR_ADDR0(VA0), .FIX_ADDR0(FA0), .DEF_ADDR(DA)
   ) i_range_reg_sequencer (
      .clk(clk), .rst_n(rst_n), .start(start),
      .has_fixed(has_fixed), .has_pge(has_pge),
      .want_type(want_type), .want_en(want_en),
      .shadow_var_base(sh_base), .shadow_var_mask(sh_mask), .shadow_fix(sh_fix),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
      .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_ack(cmd_ack),
      .busy(busy), .done(done), .chg_mask(chg_mask)
   );

   logic [63:0] mem [0:(1<<AW)-1];
   int          ev_kind [0:255];
   int          ev_a    [0:255];
   logic [63:0] ev_d    [0:255];
   int          ev_n = 0;
   int          x_kind  [0:255];
   int          x_a     [0:255];
   logic [63:0] x_d     [0:255];
   int          x_n;
   int          done_cnt = 0;
   logic [2:0]  mask_at_done = '0;
   int          n_chk = 0, n_fail = 0;
   int          cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (done) begin
         done_cnt     <= done_cnt + 1;
         mask_at_done <= chg_mask;
      end
      if (!rst_n) begin
         reg_ack <= 1'b0;
         cmd_ack <= 1'b0;
      end else begin
         if (reg_req && !reg_ack && ($urandom_range(0, 2) != 0)) begin
            reg_ack <= 1'b1;
            if (reg_we) begin
               mem[reg_addr] <= reg_wdata;
               ev_kind[ev_n] <= 1; ev_a[ev_n] <= int'(reg_addr); ev_d[ev_n] <= reg_wdata;
            end else begin
               reg_rdata     <= mem[reg_addr];
               ev_kind[ev_n] <= 0; ev_a[ev_n] <= int'(reg_addr); ev_d[ev_n] <= mem[reg_addr];
            end
            ev_n <= ev_n + 1;
         end else begin
            reg_ack <= 1'b0;
         end
         if (cmd_req && !cmd_ack && ($urandom_range(0, 3) != 0)) begin
            cmd_ack <= 1'b1;
            ev_kind[ev_n] <= 2; ev_a[ev_n] <= int'(cmd_op); ev_d[ev_n] <= '0;
            ev_n <= ev_n + 1;
         end else begin
            cmd_ack <= 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int item_addr(input int k);
      return (k < 2 * NV) ? VA0 + k : FA0 + (k - 2 * NV);
   endfunction

   function automatic logic [63:0] item_care(input int k);
      logic [63:0] pa_mask = (64'd1 << PA) - 64'd1;
      if (k >= 2 * NV) return '1;
      if (k % 2 == 0)  return pa_mask & ~64'h0000_0000_0000_0F00;
      return pa_mask & ~64'h0000_0000_0000_07FF;
   endfunction

   task automatic xadd(input int kind, input int a, input logic [63:0] d);
      x_kind[x_n] = kind; x_a[x_n] = a; x_d[x_n] = d;
      x_n++;
   endtask

   // mode 0: all equal, 1: only ignored bits differ, 2: random mix, 3: all differ
   task automatic run_case(input int mode, input bit pge, input bit fix);
      logic [63:0] old_v [NIT];
      logic [63:0] shd_v [NIT];
      logic [63:0] exp_v [NIT];
      logic [63:0] old_def, new_def, field_v;
      logic [2:0]  exp_mask;
      bit          dif, ok;
      int          m, d0, bad;
      @(negedge clk);
      exp_mask = '0;
      for (int k = 0; k < NIT; k++) begin
         old_v[k] = {$urandom, $urandom};
         m = (mode == 2) ? int'($urandom_range(0, 2)) : mode;
         case (m)
            0:       shd_v[k] = old_v[k];
            1:       shd_v[k] = (k < 2 * NV) ?
                                old_v[k] ^ ({$urandom, $urandom} & ~item_care(k)) : old_v[k];
            default: shd_v[k] = old_v[k] ^ ({$urandom, $urandom} | 64'h1000);
         endcase
         mem[item_addr(k)] = old_v[k];
         if (k < 2 * NV) begin
            if (k % 2 == 0) sh_base[(k/2)*64 +: 64] = shd_v[k];
            else            sh_mask[(k/2)*64 +: 64] = shd_v[k];
         end else begin
            sh_fix[(k - 2*NV)*64 +: 64] = shd_v[k];
         end
      end
      old_def = {$urandom, $urandom};
      mem[DA] = old_def;
      if (mode == 0 || mode == 1) begin
         want_type = old_def[7:0];
         want_en   = old_def[11:10];
      end else if (mode == 3) begin
         want_type = ~old_def[7:0];
         want_en   = old_def[11:10];
      end else begin
         want_type = 8'($urandom);
         want_en   = 2'($urandom);
      end
      has_pge   = pge;
      has_fixed = fix;
      field_v   = {52'd0, want_en, 2'b00, want_type};
      new_def   = (old_def & ~64'hCFF) | field_v;
      if (((old_def ^ field_v) & 64'hCFF) != 0) exp_mask[2] = 1'b1;

      x_n = 0;
      xadd(2, 0, 0); xadd(2, 1, 0);
      if (pge) xadd(2, 2, 0);
      xadd(2, 3, 0);
      xadd(0, DA, old_def);
      xadd(1, DA, old_def & ~64'hCFF);
      for (int k = 0; k < NIT; k++) begin
         exp_v[k] = old_v[k];
         if (k < 2 * NV || fix) begin
            xadd(0, item_addr(k), old_v[k]);
            dif = ((old_v[k] ^ shd_v[k]) & item_care(k)) != 0;
            if (dif) begin
               xadd(1, item_addr(k), shd_v[k]);
               exp_v[k] = shd_v[k];
               if (k < 2 * NV) exp_mask[0] = 1'b1;
               else            exp_mask[1] = 1'b1;
            end
         end
      end
      xadd(2, 3, 0);
      xadd(1, DA, new_def);
      xadd(2, 4, 0);
      if (pge) xadd(2, 5, 0);

      ev_n = 0;
      d0 = done_cnt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      start = 1'b1;                      // R11: pulse while busy
      @(negedge clk);
      start = 1'b0;
      for (int w = 0; w < 20000 && done_cnt == d0; w++) @(negedge clk);
      repeat (20) @(negedge clk);

      // R1 R2 R4 R8: full event order
      bad = -1;
      for (int i = 0; i < x_n; i++)
         if (bad < 0 && (i >= ev_n || ev_kind[i] != x_kind[i] ||
                         ev_a[i] != x_a[i] || ev_d[i] !== x_d[i])) bad = i;
      ok = (bad < 0) && (ev_n == x_n);
      if (bad < 0) bad = 0;
      chk(ok, "R1 R2 R4 R8", $sformatf("event order at %0d (kind/addr act %0d/%h exp %0d/%h)",
          bad, ev_kind[bad], ev_a[bad], x_kind[bad], x_a[bad]), ev_d[bad], x_d[bad]);

      ok = 1'b1; bad = 0;
      for (int k = 0; k < 2 * NV; k++)
         if (mem[item_addr(k)] !== exp_v[k] && ok) begin ok = 1'b0; bad = k; end
      chk(ok, "R5", "variable register final value", mem[item_addr(bad)], exp_v[bad]);

      ok = 1'b1; bad = 2 * NV;
      for (int k = 2 * NV; k < NIT; k++)
         if (mem[item_addr(k)] !== exp_v[k] && ok) begin ok = 1'b0; bad = k; end
      chk(ok, "R6", "fixed register final value", mem[item_addr(bad)], exp_v[bad]);

      chk(mem[DA] === new_def, "R7", "default-type final value", mem[DA], new_def);
      chk(mask_at_done === exp_mask, "R9", "change mask with done",
          64'(mask_at_done), 64'(exp_mask));
      chk(done_cnt == d0 + 1 && busy == 1'b0, "R10", "single done pulse, idle after",
          64'(done_cnt - d0), 64'd1);
      chk(ev_n == x_n, "R11", "start while busy adds no accesses",
          64'(ev_n), 64'(x_n));
   endtask

   initial begin
      void'($urandom(32'd77));
      repeat (4) @(negedge clk);
      chk(!reg_req && !cmd_req && !busy && !done, "R3", "no request out of reset",
          {60'd0, reg_req, cmd_req, busy, done}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!reg_req && !cmd_req && !busy, "R3", "quiet after reset release",
          {61'd0, reg_req, cmd_req, busy}, 64'd0);
      run_case(0, 1'b1, 1'b1);   // nothing differs
      run_case(1, 1'b1, 1'b1);   // only ignored bits differ
      run_case(3, 1'b0, 1'b1);   // everything differs, no page-global
      run_case(3, 1'b1, 1'b0);   // fixed capability off: fixed untouched
      run_case(1, 1'b0, 1'b0);
      for (int r = 0; r < 6; r++)
         run_case(2, 1'($urandom), 1'($urandom));
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule